// File: doc/BRIEF.md
# Power and Clock Domain Sleep Controller

This block gates the clock and the reset of a set of local modules, which are grouped into power domains. Software sets a target state for each module in that module's control register. It then writes a bit for a domain into a command register. The controller takes a copy of the targets for every module in that domain and raises a busy flag for the domain. After a fixed number of cycles it drops the flag and moves the new states into the status registers and onto the per-module clock-enable and reset outputs.

Each domain can be powered on or off at the same point, through a request bit in its control register. When the block is built with external power control, powering on a domain that is off stops in a waiting phase. The waiting phase ends only after an external power-good input has been seen and latched, and software has written an acknowledge bit. Module `m` belongs to domain `m % N_DOM`. Software uses a 12-bit address port with single-cycle writes and combinational reads.

Top module: `psc_ctrl`

## Requirements
- R1: After reset every module status is 0 (software-reset-disable), every clock-enable is 0, every reset output is low (asserted), every domain status is 0 (off), and busy and power requests are 0.
- R2: Module control registers at 0xA00+4m read back bits [5:0] (target state) and bit 31 (force). Domain control registers at 0x300+4d read back bit 0 (power-on request) and bit 8 (power-good acknowledge). The command register at 0x120 and unmapped addresses read 0.
- R3: A write to 0x120 with bit d set starts a transition on an idle domain d. Bit d of the busy register at 0x128 reads 1 for exactly TRANS_CYC cycles, when no handshake applies.
- R4: When a transition completes, bits [5:0] of each module status register at 0x800+4m in that domain equal the target captured when the command was accepted. Modules of other domains do not change.
- R5: Module status bit 12 reads 1 exactly when the state is 1 (synchronous reset) or 3 (enable).
- R6: `mod_clk_en[m]` is 1 for states 1 and 3. `mod_rst_n[m]` is low for states 0 and 1 and high for states 2 and 3.
- R7: A command bit for a domain that is already busy is ignored, and the running transition still ends at its original time.
- R8: A module control write made during a transition does not affect that transition. It takes effect at the next command.
- R9: When a transition completes, the domain status bit 0 at 0x200+4d takes the domain control bit 0 value captured at the command. `dom_pwr_req[d]` is high while a power-up is in progress and while the domain is on.
- R10: With external power control, powering up an off domain keeps it busy until `pwr_good[d]` has been seen. That event sets bit d of 0x070 one cycle later. The domain also waits for the acknowledge bit 8. The transition ends TRANS_CYC cycles after the first cycle in which both are held. The latched power-good bit and the acknowledge bit clear on completion.
- R11: A transition on a domain that is already on does not wait for the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational from addr) |
| pwr_good | input | N_DOM | External supply ready, per domain |
| mod_clk_en | output | N_MOD | Module clock enable |
| mod_rst_n | output | N_MOD | Module reset, active low |
| dom_pwr_req | output | N_DOM | Domain power request |

## Verification
A stale target copy or a miscounted timer shows up at the ports in two ways. The busy bit drops one cycle early or late, or the status and clock-enable of a module move at a different edge than the busy bit's fall. These are measured to the exact cycle. A domain mapping error shows at once: modules of the untouched domain change state. A broken handshake shows as a busy flag that clears before power-good and the acknowledge are both in, or that never clears.

// File: rtl/psc_ctrl.sv
module psc_ctrl #(
  parameter int N_MOD     = 4,
  parameter int N_DOM     = 2,
  parameter int TRANS_CYC = 8,
  parameter bit EXT_PWR   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [11:0]      addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [N_DOM-1:0] pwr_good,
  output logic [N_MOD-1:0] mod_clk_en,
  output logic [N_MOD-1:0] mod_rst_n,
  output logic [N_DOM-1:0] dom_pwr_req
);
  localparam int CW = $clog2(TRANS_CYC + 1);
  localparam logic [11:0] A_EPC = 12'h070, A_CMD = 12'h120, A_BSY = 12'h128,
                          A_DST = 12'h200, A_DCT = 12'h300, A_MST = 12'h800,
                          A_MCT = 12'hA00;

  logic [5:0]       tgt  [N_MOD];
  logic [5:0]       snap [N_MOD];
  logic [5:0]       mst  [N_MOD];
  logic [N_MOD-1:0] frc;
  logic [N_DOM-1:0] dreq, dack, dom_on, dtgt, busy, waiting, epc, pup;
  logic [CW-1:0]    cnt  [N_DOM];

  wire cmd_wr = wr_en && addr == A_CMD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < N_MOD; m++) begin
        tgt[m] <= '0; snap[m] <= '0; mst[m] <= '0;
      end
      for (int d = 0; d < N_DOM; d++) cnt[d] <= '0;
      frc <= '0; dreq <= '0; dack <= '0; dom_on <= '0; dtgt <= '0;
      busy <= '0; waiting <= '0; epc <= '0; pup <= '0;
    end else begin
      for (int m = 0; m < N_MOD; m++)
        if (wr_en && addr == A_MCT + 12'(4 * m)) begin
          tgt[m] <= wdata[5:0];
          frc[m] <= wdata[31];
        end
      for (int d = 0; d < N_DOM; d++) begin
        if (wr_en && addr == A_DCT + 12'(4 * d)) begin
          dreq[d] <= wdata[0];
          dack[d] <= wdata[8];
        end
        if (cmd_wr && wdata[d] && !busy[d]) begin
          busy[d]    <= 1'b1;
          dtgt[d]    <= dreq[d];
          pup[d]     <= !dom_on[d] && dreq[d];
          waiting[d] <= EXT_PWR && !dom_on[d] && dreq[d];
          cnt[d]     <= CW'(TRANS_CYC - 1);
          for (int m = 0; m < N_MOD; m++)
            if (m % N_DOM == d) snap[m] <= tgt[m];
        end else if (busy[d]) begin
          if (waiting[d]) begin
            if (pwr_good[d]) epc[d] <= 1'b1;
            if (epc[d] && dack[d]) waiting[d] <= 1'b0;
          end else if (cnt[d] == '0) begin
            busy[d]   <= 1'b0;
            dom_on[d] <= dtgt[d];
            pup[d]    <= 1'b0;
            epc[d]    <= 1'b0;
            dack[d]   <= 1'b0;
            for (int m = 0; m < N_MOD; m++)
              if (m % N_DOM == d) mst[m] <= snap[m];
          end else begin
            cnt[d] <= cnt[d] - 1'b1;
          end
        end
      end
    end
  end

  always_comb
    for (int m = 0; m < N_MOD; m++) begin
      mod_clk_en[m] = (mst[m] == 6'd1) || (mst[m] == 6'd3);
      mod_rst_n[m]  = (mst[m] != 6'd0) && (mst[m] != 6'd1);
    end

  assign dom_pwr_req = dom_on | pup;

  always_comb begin
    rdata = '0;
    if (addr == A_EPC) rdata[N_DOM-1:0] = epc;
    if (addr == A_BSY) rdata[N_DOM-1:0] = busy;
    for (int d = 0; d < N_DOM; d++) begin
      if (addr == A_DST + 12'(4 * d)) rdata[0] = dom_on[d];
      if (addr == A_DCT + 12'(4 * d)) begin
        rdata[0] = dreq[d];
        rdata[8] = dack[d];
      end
    end
    for (int m = 0; m < N_MOD; m++) begin
      if (addr == A_MST + 12'(4 * m)) begin
        rdata[5:0] = mst[m];
        rdata[12]  = mod_clk_en[m];
      end
      if (addr == A_MCT + 12'(4 * m)) begin
        rdata[5:0] = tgt[m];
        rdata[31]  = frc[m];
      end
    end
  end
endmodule

// File: rtl/psc_ctrl_chk.sv
module psc_ctrl_chk #(
  parameter int N_MOD   = 4,
  parameter int N_DOM   = 2,
  parameter bit EXT_PWR = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [11:0]      addr,
  input logic [31:0]      wdata,
  input logic [N_DOM-1:0] pwr_good,
  input logic [N_MOD-1:0] mod_clk_en,
  input logic [N_MOD-1:0] mod_rst_n,
  input logic [N_DOM-1:0] dom_pwr_req,
  input logic [N_DOM-1:0] busy,
  input logic [N_DOM-1:0] dom_on,
  input logic [N_DOM-1:0] epc
);
  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    a_r3_start_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[d]) |-> $past(wr_en && addr == 12'h120 && wdata[d]));
    a_r9_on_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_on[d]) |-> $past(dom_pwr_req[d]));
    a_r10_epc_from_pg: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(epc[d]) |-> $past(pwr_good[d]));
    a_r10_pup_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (EXT_PWR && $fell(busy[d]) && $rose(dom_on[d])) |-> $past(epc[d]));
  end
  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    a_r4_clk_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mod_clk_en[m]) |-> $fell(busy[m % N_DOM]));
    a_r6_rst_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mod_rst_n[m]) |-> $fell(busy[m % N_DOM]));
  end
endmodule

bind psc_ctrl psc_ctrl_chk #(.N_MOD(N_MOD), .N_DOM(N_DOM), .EXT_PWR(EXT_PWR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pwr_good(pwr_good), .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n),
  .dom_pwr_req(dom_pwr_req), .busy(busy), .dom_on(dom_on), .epc(epc));

// File: tb/psc_ctrl_tb.sv
`timescale 1ns/1ps
module psc_ctrl_tb;
  localparam int NM = 4, ND = 2, TC = 8;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [ND-1:0] pwr_good = '0, dom_pwr_req;
  logic [NM-1:0] mod_clk_en, mod_rst_n;
  int checks = 0, fails = 0, cyc = 0;
  logic [5:0] ctl [NM];
  logic [5:0] st  [NM];

  psc_ctrl #(.N_MOD(NM), .N_DOM(ND), .TRANS_CYC(TC), .EXT_PWR(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwr_good(pwr_good), .mod_clk_en(mod_clk_en),
    .mod_rst_n(mod_rst_n), .dom_pwr_req(dom_pwr_req));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk); wr_en = 1; addr = a; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic busy_len(input int d, output int n);
    n = 0; addr = 12'h128; #1;
    while (rdata[d] && n < 1000) begin
      n++; @(negedge clk); addr = 12'h128; #1;
    end
  endtask

  task automatic check_mods(input string req);
    logic [31:0] v;
    for (int m = 0; m < NM; m++) begin
      logic run;
      run = (st[m] == 1 || st[m] == 3);
      rd(12'h800 + 12'(4 * m), v);
      chk(req, v, {19'd0, run, 6'd0, st[m]});
      chk("R6 clk_en", {31'd0, mod_clk_en[m]}, {31'd0, run});
      chk("R6 rst_n", {31'd0, mod_rst_n[m]}, {31'd0, st[m] >= 2});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    for (int m = 0; m < NM; m++) begin ctl[m] = 0; st[m] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check_mods("R1 reset mstat");
    for (int d = 0; d < ND; d++) begin
      rd(12'h200 + 12'(4 * d), v); chk("R1 dstat", v, 0);
    end
    rd(12'h128, v); chk("R1 busy", v, 0);
    chk("R1 pwr_req", {30'd0, dom_pwr_req}, 0);
    // R2 readback
    wr(12'hA04, 32'h8000_0003); rd(12'hA04, v); chk("R2 mctl", v, 32'h8000_0003);
    wr(12'hA04, 32'h0); ctl[1] = 0;
    wr(12'h300, 32'h101); rd(12'h300, v); chk("R2 dctl", v, 32'h101);
    wr(12'h300, 32'h0);
    rd(12'h004, v); chk("R2 unmapped", v, 0);
    rd(12'h120, v); chk("R2 cmd reads 0", v, 0);
    // R3 R4 R5 R6 sweep over states and domains, domains kept off
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < ND; d++) begin
        for (int m = d; m < NM; m += ND) begin
          ctl[m] = 6'((s + m) % 4);
          wr(12'hA00 + 12'(4 * m), {s[0], 25'd0, ctl[m]});
        end
        wr(12'h120, 32'(1 << d));
        busy_len(d, n); chk("R3 busy length", n, TC);
        for (int m = d; m < NM; m += ND) st[m] = ctl[m];
        check_mods("R4 R5 mstat");
        rd(12'h200 + 12'(4 * d), v); chk("R9 stays off", v, 0);
      end
    // R7 R8 command while busy, control write while busy
    ctl[0] = 3; wr(12'hA00, 32'd3);
    wr(12'h120, 32'h1);
    ctl[0] = 1; wr(12'hA00, 32'd1);
    wr(12'h120, 32'h1);
    busy_len(0, n); chk("R7 ignored cmd keeps end", n, 4);
    st[0] = 3; st[2] = ctl[2];
    check_mods("R8 old target used");
    wr(12'h120, 32'h1);
    busy_len(0, n); chk("R8 next cmd length", n, TC);
    st[0] = 1;
    check_mods("R8 new target used");
    // R10 handshake on domain 1
    wr(12'h304, 32'h1);
    wr(12'h120, 32'h2);
    repeat (20) @(negedge clk);
    rd(12'h128, v); chk("R10 waits for pg", v[1], 1);
    rd(12'h070, v); chk("R10 epc clear before pg", v, 0);
    chk("R9 req during power-up", {30'd0, dom_pwr_req}, 32'h2);
    @(negedge clk); pwr_good = 2'b10;
    rd(12'h070, v); chk("R10 epc latched", v, 32'h2);
    repeat (5) @(negedge clk);
    rd(12'h128, v); chk("R10 waits for ack", v[1], 1);
    wr(12'h304, 32'h101);
    busy_len(1, n); chk("R10 length after ack", n, TC + 1);
    pwr_good = 0;
    rd(12'h204, v); chk("R9 domain on", v, 1);
    rd(12'h070, v); chk("R10 epc cleared", v, 0);
    rd(12'h304, v); chk("R10 ack cleared", v, 1);
    chk("R9 req while on", {30'd0, dom_pwr_req}, 32'h2);
    check_mods("R4 after power-up");
    // R11 on domain: no handshake
    wr(12'h120, 32'h2);
    busy_len(1, n); chk("R11 no wait when on", n, TC);
    // R9 power down
    wr(12'h304, 32'h0);
    wr(12'h120, 32'h2);
    busy_len(1, n); chk("R9 power-down length", n, TC);
    rd(12'h204, v); chk("R9 domain off", v, 0);
    chk("R9 req dropped", {30'd0, dom_pwr_req}, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule